// File: doc/BRIEF.md
# Power Management Event Router

This block gathers power management event requests into sticky status bits and steers them to two interrupt outputs. One is a legacy system-management interrupt (SMI) and the other is an ACPI system-control interrupt (SCI). Software selects SMI, SCI or both through two route enables. A separate group of wake events can raise SCI through a global enable. An optional bridge forwards the SMI event group into SCI as well.

The SCI request then passes through an output stage that software configures. It selects the active polarity and either push-pull or emulated open-drain drive. It also places the signal on a dedicated pin or on one of several IRQ lines. Software reaches every control, enable and status bit through a byte-wide register port with a 3-bit address. Writes take effect at the clock edge. Reads are combinational.

Top module: `pm_event_router`

Register map (address: content):
- 0 `PMCTL`: bit 0 `sci_route` sends enabled SMI-group events to SCI.
- 1 `SMISTS`: SMI-group status, one bit per source, write one to clear.
- 2 `SMIMSK`: SMI-group per-source enables.
- 3 `SMIRTE`: bit 7 `smi_route` sends enabled SMI-group events to SMI; bit 6 `bridge_arm`.
- 4 `WAKSTS`: wake-group status, write one to clear.
- 5 `WAKMSK`: wake-group per-source enables.
- 6 `WAKCTL`: bit 0 `wake_global`; bit 1 `devint_arm`.
- 7 `OUTCFG`: bits 2:0 destination code; bit 3 `act_high`; bit 4 `open_drain`.

## Requirements
- R1: After reset every register reads 0, `smi_o` and `sci_o` are 0, `irq_o` and `irq_oe_o` are all 0, and the dedicated pin idles high with `pin_oe_o`=1 (push-pull, active low, inactive).
- R2: A status bit in SMISTS or WAKSTS is set at any clock edge where its event input is high, and it stays set until software writes 1 to it. Writing 0 leaves it unchanged. An event that is high in the same cycle as a clearing write keeps the bit set.
- R3: `smi_o` is 1 exactly when SMIRTE bit 7 is 1 and some SMISTS bit has its SMIMSK bit set.
- R4: With PMCTL bit 0 set, any enabled SMI-group status bit drives `sci_o` to 1. With the bit clear and no other SCI path active, `sci_o` is 0.
- R5: With both SMIRTE bit 7 and PMCTL bit 0 set, one enabled SMI-group event asserts `smi_o` and `sci_o` together.
- R6: `sci_o` is asserted when WAKCTL bit 0 is set and some WAKSTS bit has its WAKMSK bit set. It is not asserted through this path while WAKCTL bit 0 is clear.
- R7: Enabled SMI-group events reach `sci_o` through the bridge only while both WAKCTL bit 1 and SMIRTE bit 6 are set. Either bit alone has no effect.
- R8: In push-pull mode (OUTCFG bit 4 = 0) the selected destination drives with output enable 1. Its level equals `sci_o` when OUTCFG bit 3 = 1 and the inverse of `sci_o` when bit 3 = 0.
- R9: In open-drain mode (OUTCFG bit 4 = 1) the selected destination drives value 0. Its output enable is 1 only when the polarity-adjusted level is low.
- R10: Destination code 0 selects the dedicated pin. Code k (1 to N_IRQ) selects `irq_o[k-1]`. Any other code leaves every destination with output 0 and enable 0. Unselected destinations always have output 0 and enable 0.
- R11: Register bits that are not implemented read as 0. PMCTL reads 0x01, SMIRTE 0xC0, WAKCTL 0x03 and OUTCFG 0x1F after writing 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| smi_evt_i | input | N_SMI (8) | SMI-group event requests |
| wake_evt_i | input | N_WAKE (8) | Wake-group event requests |
| smi_o | output | 1 | SMI request, active high |
| sci_o | output | 1 | Internal SCI request, active high |
| pin_o | output | 1 | Dedicated pin drive value |
| pin_oe_o | output | 1 | Dedicated pin output enable |
| irq_o | output | N_IRQ (6) | IRQ line drive values |
| irq_oe_o | output | N_IRQ (6) | IRQ line output enables |

## Verification
The assertions assume that the event inputs and the register port are driven synchronously and hold stable across each rising edge. They also assume that only one register access is presented per cycle. The one-hot check on the IRQ enables assumes the destination code is the only thing that selects a line. The bench changes every input on the falling edge and holds it for a full period. It issues writes one at a time through a single task. The out-of-range destination code is driven only through the normal register write path.

// File: rtl/pm_route_pkg.sv
package pm_route_pkg;
   typedef enum logic [2:0] {
      RA_PMCTL  = 3'd0,
      RA_SMISTS = 3'd1,
      RA_SMIMSK = 3'd2,
      RA_SMIRTE = 3'd3,
      RA_WAKSTS = 3'd4,
      RA_WAKMSK = 3'd5,
      RA_WAKCTL = 3'd6,
      RA_OUTCFG = 3'd7
   } reg_addr_e;

   localparam int unsigned ADDR_W        = 3;
   localparam int unsigned BIT_SCI_ROUTE = 0;
   localparam int unsigned BIT_WAKE_GLB  = 0;
   localparam int unsigned BIT_DEVINT    = 1;
endpackage

// File: rtl/pm_route_w1c.sv
module pm_route_w1c #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] evt_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] sts_o
);
   generate
      if (W < 1) begin : g_bad_w
         $error("pm_route_w1c: W must be at least 1");
      end
   endgenerate

   logic [W-1:0] sts_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sts_q <= '0;
      else        sts_q <= (sts_q & ~clr_i) | evt_i;
   end

   assign sts_o = sts_q;

   AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i != '0) |=> ((sts_q & $past(clr_i & ~evt_i)) == '0)); // R2
   AST_EVT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_i != '0) |=> ((sts_q & $past(evt_i)) == $past(evt_i))); // R2
   AST_HOLD_NO_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i == '0) |=> ((sts_q & $past(sts_q)) == $past(sts_q))); // R2
endmodule

// File: rtl/pm_route_regs.sv
module pm_route_regs
   import pm_route_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned N_SMI  = 8,
   parameter int unsigned N_WAKE = 8,
   parameter int unsigned SEL_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [N_SMI-1:0]  smi_evt_i,
   input  logic [N_WAKE-1:0] wake_evt_i,
   output logic [N_SMI-1:0]  smi_sts_o,
   output logic [N_SMI-1:0]  smi_msk_o,
   output logic [N_WAKE-1:0] wake_sts_o,
   output logic [N_WAKE-1:0] wake_msk_o,
   output logic              sci_route_o,
   output logic              smi_route_o,
   output logic              bridge_arm_o,
   output logic              wake_glb_o,
   output logic              devint_arm_o,
   output logic [SEL_W-1:0]  dest_sel_o,
   output logic              act_high_o,
   output logic              open_drain_o
);
   localparam int unsigned BIT_SMI_ROUTE = DATA_W - 1;
   localparam int unsigned BIT_BRIDGE    = DATA_W - 2;
   localparam int unsigned BIT_ACT_HIGH  = SEL_W;
   localparam int unsigned BIT_OPEN_DR   = SEL_W + 1;

   generate
      if (N_SMI > DATA_W || N_WAKE > DATA_W) begin : g_bad_n
         $error("pm_route_regs: event groups wider than the data path");
      end
      if (SEL_W + 2 > DATA_W) begin : g_bad_sel
         $error("pm_route_regs: OUTCFG fields do not fit the data path");
      end
      if (DATA_W < 4) begin : g_bad_dw
         $error("pm_route_regs: DATA_W must be at least 4");
      end
   endgenerate

   logic wr_pmctl, wr_smists, wr_smimsk, wr_smirte;
   logic wr_waksts, wr_wakmsk, wr_wakctl, wr_outcfg;

   always_comb begin
      wr_pmctl  = reg_we && (reg_addr == RA_PMCTL);
      wr_smists = reg_we && (reg_addr == RA_SMISTS);
      wr_smimsk = reg_we && (reg_addr == RA_SMIMSK);
      wr_smirte = reg_we && (reg_addr == RA_SMIRTE);
      wr_waksts = reg_we && (reg_addr == RA_WAKSTS);
      wr_wakmsk = reg_we && (reg_addr == RA_WAKMSK);
      wr_wakctl = reg_we && (reg_addr == RA_WAKCTL);
      wr_outcfg = reg_we && (reg_addr == RA_OUTCFG);
   end

   logic [N_SMI-1:0]  smi_clr;
   logic [N_WAKE-1:0] wake_clr;
   assign smi_clr  = wr_smists ? reg_wdata[N_SMI-1:0]  : '0;
   assign wake_clr = wr_waksts ? reg_wdata[N_WAKE-1:0] : '0;

   pm_route_w1c #(.W(N_SMI)) u_smi_sts (
      .clk   (clk),
      .rst_n (rst_n),
      .evt_i (smi_evt_i),
      .clr_i (smi_clr),
      .sts_o (smi_sts_o)
   );

   pm_route_w1c #(.W(N_WAKE)) u_wake_sts (
      .clk   (clk),
      .rst_n (rst_n),
      .evt_i (wake_evt_i),
      .clr_i (wake_clr),
      .sts_o (wake_sts_o)
   );

   logic [N_SMI-1:0]  smi_msk_q;
   logic [N_WAKE-1:0] wake_msk_q;
   logic              sci_route_q, smi_route_q, bridge_q, wake_glb_q, devint_q;
   logic [SEL_W-1:0]  sel_q;
   logic              act_high_q, open_dr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         smi_msk_q   <= '0;
         wake_msk_q  <= '0;
         sci_route_q <= 1'b0;
         smi_route_q <= 1'b0;
         bridge_q    <= 1'b0;
         wake_glb_q  <= 1'b0;
         devint_q    <= 1'b0;
         sel_q       <= '0;
         act_high_q  <= 1'b0;
         open_dr_q   <= 1'b0;
      end else begin
         if (wr_pmctl)  sci_route_q <= reg_wdata[BIT_SCI_ROUTE];
         if (wr_smimsk) smi_msk_q   <= reg_wdata[N_SMI-1:0];
         if (wr_wakmsk) wake_msk_q  <= reg_wdata[N_WAKE-1:0];
         if (wr_smirte) begin
            smi_route_q <= reg_wdata[BIT_SMI_ROUTE];
            bridge_q    <= reg_wdata[BIT_BRIDGE];
         end
         if (wr_wakctl) begin
            wake_glb_q <= reg_wdata[BIT_WAKE_GLB];
            devint_q   <= reg_wdata[BIT_DEVINT];
         end
         if (wr_outcfg) begin
            sel_q      <= reg_wdata[SEL_W-1:0];
            act_high_q <= reg_wdata[BIT_ACT_HIGH];
            open_dr_q  <= reg_wdata[BIT_OPEN_DR];
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      unique case (reg_addr)
         RA_PMCTL:  reg_rdata[BIT_SCI_ROUTE] = sci_route_q;
         RA_SMISTS: reg_rdata[N_SMI-1:0]     = smi_sts_o;
         RA_SMIMSK: reg_rdata[N_SMI-1:0]     = smi_msk_q;
         RA_SMIRTE: begin
            reg_rdata[BIT_SMI_ROUTE] = smi_route_q;
            reg_rdata[BIT_BRIDGE]    = bridge_q;
         end
         RA_WAKSTS: reg_rdata[N_WAKE-1:0]    = wake_sts_o;
         RA_WAKMSK: reg_rdata[N_WAKE-1:0]    = wake_msk_q;
         RA_WAKCTL: begin
            reg_rdata[BIT_WAKE_GLB] = wake_glb_q;
            reg_rdata[BIT_DEVINT]   = devint_q;
         end
         RA_OUTCFG: begin
            reg_rdata[SEL_W-1:0]    = sel_q;
            reg_rdata[BIT_ACT_HIGH] = act_high_q;
            reg_rdata[BIT_OPEN_DR]  = open_dr_q;
         end
         default: reg_rdata = '0;
      endcase
   end

   assign smi_msk_o    = smi_msk_q;
   assign wake_msk_o   = wake_msk_q;
   assign sci_route_o  = sci_route_q;
   assign smi_route_o  = smi_route_q;
   assign bridge_arm_o = bridge_q;
   assign wake_glb_o   = wake_glb_q;
   assign devint_arm_o = devint_q;
   assign dest_sel_o   = sel_q;
   assign act_high_o   = act_high_q;
   assign open_drain_o = open_dr_q;
endmodule

// File: rtl/pm_route_core.sv
module pm_route_core #(
   parameter int unsigned N_SMI  = 8,
   parameter int unsigned N_WAKE = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SMI-1:0]  smi_sts_i,
   input  logic [N_SMI-1:0]  smi_msk_i,
   input  logic [N_WAKE-1:0] wake_sts_i,
   input  logic [N_WAKE-1:0] wake_msk_i,
   input  logic              sci_route_i,
   input  logic              smi_route_i,
   input  logic              bridge_arm_i,
   input  logic              wake_glb_i,
   input  logic              devint_arm_i,
   output logic              smi_o,
   output logic              sci_o
);
   logic smi_pend, wake_pend, bridge_open;

   assign smi_pend    = |(smi_sts_i & smi_msk_i);
   assign wake_pend   = |(wake_sts_i & wake_msk_i);
   assign bridge_open = bridge_arm_i & devint_arm_i;

   assign smi_o = smi_route_i & smi_pend;
   assign sci_o = (sci_route_i & smi_pend)
                | (wake_glb_i & wake_pend)
                | (bridge_open & smi_pend);

   AST_SMI_NEEDS_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
      smi_o |-> smi_route_i); // R3
   AST_SCI_HAS_PATH: assert property (@(posedge clk) disable iff (!rst_n)
      sci_o |-> (sci_route_i || wake_glb_i || (bridge_arm_i && devint_arm_i))); // R4
   AST_DUAL_DELIVERY: assert property (@(posedge clk) disable iff (!rst_n)
      (smi_o && sci_route_i) |-> sci_o); // R5
endmodule

// File: rtl/pm_route_drive.sv
module pm_route_drive #(
   parameter int unsigned N_IRQ = 6,
   parameter int unsigned SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_i,
   input  logic [SEL_W-1:0] sel_i,
   input  logic             act_high_i,
   input  logic             open_drain_i,
   output logic             pin_o,
   output logic             pin_oe_o,
   output logic [N_IRQ-1:0] irq_o,
   output logic [N_IRQ-1:0] irq_oe_o
);
   generate
      if (N_IRQ < 1 || N_IRQ + 1 > (1 << SEL_W)) begin : g_bad_irq
         $error("pm_route_drive: N_IRQ does not fit the destination code");
      end
   endgenerate

   logic lvl, drv_val, drv_oe;

   assign lvl = act_high_i ? req_i : ~req_i;

   always_comb begin
      if (open_drain_i) begin
         drv_val = 1'b0;
         drv_oe  = ~lvl;
      end else begin
         drv_val = lvl;
         drv_oe  = 1'b1;
      end
   end

   logic pin_sel;
   assign pin_sel  = (sel_i == '0);
   assign pin_o    = pin_sel & drv_val;
   assign pin_oe_o = pin_sel & drv_oe;

   generate
      for (genvar i = 0; i < N_IRQ; i++) begin : g_irq
         localparam logic [SEL_W-1:0] CODE = SEL_W'(i + 1);
         logic hit;
         assign hit         = (sel_i == CODE);
         assign irq_o[i]    = hit & drv_val;
         assign irq_oe_o[i] = hit & drv_oe;
      end
   endgenerate

   AST_ONE_IRQ_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(irq_oe_o)); // R10
   AST_PIN_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      pin_oe_o |-> (irq_oe_o == '0)); // R10
   AST_OD_PULLS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      open_drain_i |-> (!pin_o && irq_o == '0)); // R9
   AST_PP_ALWAYS_ON: assert property (@(posedge clk) disable iff (!rst_n)
      (!open_drain_i && sel_i == '0) |-> pin_oe_o); // R8
endmodule

// File: rtl/pm_event_router.sv
module pm_event_router
   import pm_route_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned N_SMI  = 8,
   parameter int unsigned N_WAKE = 8,
   parameter int unsigned N_IRQ  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [2:0]        reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [N_SMI-1:0]  smi_evt_i,
   input  logic [N_WAKE-1:0] wake_evt_i,
   output logic              smi_o,
   output logic              sci_o,
   output logic              pin_o,
   output logic              pin_oe_o,
   output logic [N_IRQ-1:0]  irq_o,
   output logic [N_IRQ-1:0]  irq_oe_o
);
   localparam int unsigned SEL_W = $clog2(N_IRQ + 1);

   logic [N_SMI-1:0]  smi_sts, smi_msk;
   logic [N_WAKE-1:0] wake_sts, wake_msk;
   logic              sci_route, smi_route, bridge_arm, wake_glb, devint_arm;
   logic [SEL_W-1:0]  dest_sel;
   logic              act_high, open_drain;

   pm_route_regs #(
      .DATA_W (DATA_W),
      .N_SMI  (N_SMI),
      .N_WAKE (N_WAKE),
      .SEL_W  (SEL_W)
   ) u_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .reg_we       (reg_we),
      .reg_addr     (reg_addr),
      .reg_wdata    (reg_wdata),
      .reg_rdata    (reg_rdata),
      .smi_evt_i    (smi_evt_i),
      .wake_evt_i   (wake_evt_i),
      .smi_sts_o    (smi_sts),
      .smi_msk_o    (smi_msk),
      .wake_sts_o   (wake_sts),
      .wake_msk_o   (wake_msk),
      .sci_route_o  (sci_route),
      .smi_route_o  (smi_route),
      .bridge_arm_o (bridge_arm),
      .wake_glb_o   (wake_glb),
      .devint_arm_o (devint_arm),
      .dest_sel_o   (dest_sel),
      .act_high_o   (act_high),
      .open_drain_o (open_drain)
   );

   pm_route_core #(
      .N_SMI  (N_SMI),
      .N_WAKE (N_WAKE)
   ) u_core (
      .clk          (clk),
      .rst_n        (rst_n),
      .smi_sts_i    (smi_sts),
      .smi_msk_i    (smi_msk),
      .wake_sts_i   (wake_sts),
      .wake_msk_i   (wake_msk),
      .sci_route_i  (sci_route),
      .smi_route_i  (smi_route),
      .bridge_arm_i (bridge_arm),
      .wake_glb_i   (wake_glb),
      .devint_arm_i (devint_arm),
      .smi_o        (smi_o),
      .sci_o        (sci_o)
   );

   pm_route_drive #(
      .N_IRQ (N_IRQ),
      .SEL_W (SEL_W)
   ) u_drive (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_i        (sci_o),
      .sel_i        (dest_sel),
      .act_high_i   (act_high),
      .open_drain_i (open_drain),
      .pin_o        (pin_o),
      .pin_oe_o     (pin_oe_o),
      .irq_o        (irq_o),
      .irq_oe_o     (irq_oe_o)
   );
endmodule

// File: tb/pm_event_router_tb.sv
module pm_event_router_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_we = 1'b0;
   logic [2:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic [7:0] smi_evt_i = '0;
   logic [7:0] wake_evt_i = '0;
   logic       smi_o, sci_o, pin_o, pin_oe_o;
   logic [5:0] irq_o, irq_oe_o;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   pm_event_router dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_we     (reg_we),
      .reg_addr   (reg_addr),
      .reg_wdata  (reg_wdata),
      .reg_rdata  (reg_rdata),
      .smi_evt_i  (smi_evt_i),
      .wake_evt_i (wake_evt_i),
      .smi_o      (smi_o),
      .sci_o      (sci_o),
      .pin_o      (pin_o),
      .pin_oe_o   (pin_oe_o),
      .irq_o      (irq_o),
      .irq_oe_o   (irq_oe_o)
   );

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic pulse_smi(input logic [7:0] v);
      @(negedge clk); smi_evt_i = v;
      @(negedge clk); smi_evt_i = '0;
   endtask

   task automatic pulse_wake(input logic [7:0] v);
      @(negedge clk); wake_evt_i = v;
      @(negedge clk); wake_evt_i = '0;
   endtask

   task automatic clear_all();
      for (int a = 0; a < 8; a++) wr(3'(a), (a == 1 || a == 4) ? 8'hFF : 8'h00);
   endtask

   task automatic t_reset();
      logic [7:0] d;
      for (int a = 0; a < 8; a++) begin
         rd(3'(a), d);
         chk("R1", "reg after reset", d, 8'h00);
      end
      chk("R1", "smi_o", smi_o, 1'b0);
      chk("R1", "sci_o", sci_o, 1'b0);
      chk("R1", "pin_o", pin_o, 1'b1);
      chk("R1", "pin_oe_o", pin_oe_o, 1'b1);
      chk("R1", "irq_o", irq_o, 6'h00);
      chk("R1", "irq_oe_o", irq_oe_o, 6'h00);
   endtask

   task automatic t_status();
      logic [7:0] d;
      pulse_smi(8'h04);
      rd(3'd1, d); chk("R2", "SMISTS set", d, 8'h04);
      wr(3'd1, 8'h00);
      rd(3'd1, d); chk("R2", "SMISTS write 0 holds", d, 8'h04);
      wr(3'd1, 8'h04);
      rd(3'd1, d); chk("R2", "SMISTS W1C", d, 8'h00);
      @(negedge clk);
      smi_evt_i = 8'h04; reg_we = 1'b1; reg_addr = 3'd1; reg_wdata = 8'h04;
      @(negedge clk);
      smi_evt_i = '0; reg_we = 1'b0;
      rd(3'd1, d); chk("R2", "event beats clear", d, 8'h04);
      pulse_wake(8'h81);
      rd(3'd4, d); chk("R2", "WAKSTS set", d, 8'h81);
      wr(3'd4, 8'h01);
      rd(3'd4, d); chk("R2", "WAKSTS partial clear", d, 8'h80);
      clear_all();
   endtask

   task automatic t_smi();
      pulse_smi(8'h04);
      wr(3'd2, 8'h04);
      @(negedge clk);
      chk("R3", "smi_o without route", smi_o, 1'b0);
      wr(3'd3, 8'h80);
      @(negedge clk);
      chk("R3", "smi_o routed", smi_o, 1'b1);
      chk("R4", "sci_o with sci_route clear", sci_o, 1'b0);
      wr(3'd2, 8'h01);
      @(negedge clk);
      chk("R3", "smi_o masked source", smi_o, 1'b0);
      wr(3'd2, 8'h04);
      wr(3'd0, 8'h01);
      @(negedge clk);
      chk("R5", "dual smi_o", smi_o, 1'b1);
      chk("R5", "dual sci_o", sci_o, 1'b1);
      wr(3'd3, 8'h00);
      @(negedge clk);
      chk("R4", "sci only smi_o", smi_o, 1'b0);
      chk("R4", "sci only sci_o", sci_o, 1'b1);
      wr(3'd1, 8'h04);
      @(negedge clk);
      chk("R4", "sci drops after clear", sci_o, 1'b0);
      clear_all();
   endtask

   task automatic t_wake();
      pulse_wake(8'h20);
      wr(3'd5, 8'h20);
      @(negedge clk);
      chk("R6", "wake without global", sci_o, 1'b0);
      wr(3'd6, 8'h01);
      @(negedge clk);
      chk("R6", "wake with global", sci_o, 1'b1);
      chk("R6", "smi_o untouched", smi_o, 1'b0);
      wr(3'd5, 8'h10);
      @(negedge clk);
      chk("R6", "wake masked", sci_o, 1'b0);
      clear_all();
   endtask

   task automatic t_bridge();
      pulse_smi(8'h10);
      wr(3'd2, 8'h10);
      wr(3'd3, 8'h40);
      @(negedge clk);
      chk("R7", "bridge_arm alone", sci_o, 1'b0);
      wr(3'd6, 8'h02);
      @(negedge clk);
      chk("R7", "both bridge bits", sci_o, 1'b1);
      chk("R7", "smi_o not routed", smi_o, 1'b0);
      wr(3'd3, 8'h00);
      @(negedge clk);
      chk("R7", "devint alone", sci_o, 1'b0);
      clear_all();
   endtask

   task automatic t_drive();
      chk("R8", "idle pp low-active pin", {pin_o, pin_oe_o}, 2'b11);
      wr(3'd7, 8'h08);
      @(negedge clk);
      chk("R8", "idle pp high-active pin", {pin_o, pin_oe_o}, 2'b01);
      pulse_wake(8'h01); wr(3'd5, 8'h01); wr(3'd6, 8'h01);
      @(negedge clk);
      chk("R8", "active pp high-active pin", {pin_o, pin_oe_o}, 2'b11);
      wr(3'd7, 8'h00);
      @(negedge clk);
      chk("R8", "active pp low-active pin", {pin_o, pin_oe_o}, 2'b01);
      wr(3'd7, 8'h10);
      @(negedge clk);
      chk("R9", "active od low-active pin", {pin_o, pin_oe_o}, 2'b01);
      wr(3'd7, 8'h18);
      @(negedge clk);
      chk("R9", "active od high-active pin", {pin_o, pin_oe_o}, 2'b00);
      wr(3'd7, 8'h03);
      @(negedge clk);
      chk("R10", "code 3 pin off", {pin_o, pin_oe_o}, 2'b00);
      chk("R10", "code 3 irq_o", irq_o, 6'h00);
      chk("R10", "code 3 irq_oe_o", irq_oe_o, 6'h04);
      wr(3'd7, 8'h0E);
      @(negedge clk);
      chk("R10", "code 6 irq_o", irq_o, 6'h20);
      chk("R10", "code 6 irq_oe_o", irq_oe_o, 6'h20);
      wr(3'd7, 8'h0F);
      @(negedge clk);
      chk("R10", "code 7 disconnects", {pin_o, pin_oe_o, irq_o, irq_oe_o}, 14'h0);
      wr(3'd4, 8'h01);
      wr(3'd7, 8'h11);
      @(negedge clk);
      chk("R9", "idle od low-active irq0", {irq_o[0], irq_oe_o[0]}, 2'b00);
      clear_all();
   endtask

   task automatic t_readback();
      logic [7:0] d;
      wr(3'd0, 8'hFF); rd(3'd0, d); chk("R11", "PMCTL", d, 8'h01);
      wr(3'd3, 8'hFF); rd(3'd3, d); chk("R11", "SMIRTE", d, 8'hC0);
      wr(3'd6, 8'hFF); rd(3'd6, d); chk("R11", "WAKCTL", d, 8'h03);
      wr(3'd7, 8'hFF); rd(3'd7, d); chk("R11", "OUTCFG", d, 8'h1F);
      wr(3'd2, 8'hA5); rd(3'd2, d); chk("R11", "SMIMSK", d, 8'hA5);
      clear_all();
   endtask

   task automatic summary();
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_status();
      t_smi();
      t_wake();
      t_bridge();
      t_drive();
      t_readback();
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      #80000;
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         summary();
         $finish;
      end
   end
endmodule